// File: doc/BRIEF.md
# Byte-Pair DAC Write Latch

This block sits between a host write port and the input registers of several 12-bit DAC channels. Each channel takes up two consecutive addresses. The even address stages the four least significant bits of a code. The odd address supplies the eight most significant bits, and that write completes the code. The host can also send a full 16-bit word, which stages the low bits and completes the code in a single cycle. A DAC input register only ever changes when a code is complete, so the analog output never shows a mix of old and new bits.

Every completed code first enters a per-channel pending rank. In immediate mode the same code also goes straight to the DAC input register. In simultaneous mode the DAC input registers stay frozen while the pending rank collects new codes. A shared load strobe then moves every channel's pending code to its DAC input register on the same clock edge. After reset every channel outputs mid-scale, code 2048.

Top module: `dac_pair_latch`

## Requirements
- R1: After reset every channel's `dac_code` field reads 2048 (0x800), every pending code is 2048 and every staged low nibble is 0.
- R2: A byte write (`wr_word`=0) to an even address stages `wr_data[3:0]` as the low nibble of channel `wr_addr[2:1]`. Bits `wr_data[15:4]` are ignored, and no `dac_code` field changes.
- R3: In immediate mode (`sim_mode`=0), a byte write to an odd address sets that channel's `dac_code` on the next edge to {`wr_data[7:0]`, staged nibble}. Bits `wr_data[15:8]` are ignored.
- R4: A word write (`wr_word`=1) addresses channel `wr_addr[2:1]` and ignores `wr_addr[0]`. It forms the code {`wr_data[15:8]`, `wr_data[3:0]`} and stores `wr_data[3:0]` as the new staged nibble. The staged nibble and the code take effect on the same edge.
- R5: A staged nibble stays in place after a high-byte write. Later high-byte writes reuse it until another low-byte or word write replaces it.
- R6: In simultaneous mode (`sim_mode`=1), completed codes do not reach `dac_code`. With `load`=1, every channel's pending code is copied to `dac_code` on the next edge. In immediate mode `load` has no effect.
- R7: If a write completes a code in the same cycle as a simultaneous-mode load, the load moves the pending contents from before that write. The new code waits for the next load.
- R8: A write whose channel index (`wr_addr[2:1]`) is NCH or above changes no state in any channel.
- R9: A write to one channel never changes another channel's staged nibble, pending code or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1: 16-bit word write, 0: byte write on wr_data[7:0] |
| wr_addr | input | 3 | {channel, high-byte select} |
| wr_data | input | 16 | Write data |
| sim_mode | input | 1 | 1: hold outputs until load |
| load | input | 1 | Common transfer strobe for simultaneous mode |
| dac_code | output | 36 | Channel n code at bits [12n+11:12n] |

## Verification
The bench goes after the ordering corner cases. One is a high byte written with no fresh low byte, where a design that clears the nibble would emit the wrong LSBs. Another is a word write to an odd address, where a design that decodes bit 0 would drop the low nibble. A third is a load that coincides with a write, where a design that forwards the write would release a code too early. Out-of-range channel writes and immediate-mode load strobes are also applied. A design that aliases those channels, or lets load act outside simultaneous mode, would corrupt a live channel's output.

// File: rtl/dac_pair_latch.sv
module dac_pair_latch #(
  parameter int NCH    = 3,
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_word,
  input  logic [$clog2(NCH):0]    wr_addr,
  input  logic [2*BYTE_W-1:0]     wr_data,
  input  logic                    sim_mode,
  input  logic                    load,
  output logic [NCH*CODE_W-1:0]   dac_code
);
  localparam int LO_W   = CODE_W - BYTE_W;
  localparam int CH_W   = $clog2(NCH);
  localparam int ADDR_W = CH_W + 1;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CH_W-1:0] wch;
  logic            in_rng;
  logic [NCH*CODE_W-1:0] pend_flat;
  logic [NCH*LO_W-1:0]   lo_flat;

  assign wch    = wr_addr[ADDR_W-1:1];
  assign in_rng = 32'(wch) < NCH;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [LO_W-1:0]   lo_q;
    logic [CODE_W-1:0] pend_q, dac_q, new_code;
    logic              sel, lo_wr, hi_wr;

    assign sel      = wr_en && in_rng && (wch == CH_W'(g));
    assign lo_wr    = sel && (wr_word || !wr_addr[0]);
    assign hi_wr    = sel && (wr_word ||  wr_addr[0]);
    assign new_code = wr_word ? {wr_data[2*BYTE_W-1:BYTE_W], wr_data[LO_W-1:0]}
                              : {wr_data[BYTE_W-1:0], lo_q};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q   <= '0;
        pend_q <= MID;
        dac_q  <= MID;
      end else begin
        if (lo_wr) lo_q <= wr_data[LO_W-1:0];
        if (hi_wr) pend_q <= new_code;
        if (sim_mode) begin
          if (load) dac_q <= pend_q;
        end else if (hi_wr) begin
          dac_q <= new_code;
        end
      end
    end

    assign dac_code[g*CODE_W +: CODE_W] = dac_q;
    assign pend_flat[g*CODE_W +: CODE_W] = pend_q;
    assign lo_flat[g*LO_W +: LO_W] = lo_q;
  end

  p_lowbyte_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && !wr_addr[0] && !(sim_mode && load)) |=> $stable(dac_code));

  p_sim_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_mode && !load) |=> $stable(dac_code));

  p_sim_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_mode && load) |=> (dac_code == $past(pend_flat)));

  p_out_of_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rng && !(sim_mode && load)) |=>
      ($stable(dac_code) && $stable(pend_flat) && $stable(lo_flat)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(sim_mode && load)) |=>
      ($stable(dac_code) && $stable(pend_flat) && $stable(lo_flat)));
endmodule

// File: tb/dac_pair_latch_tb.sv
module dac_pair_latch_tb;
  localparam int NCH = 3;
  localparam int CW  = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, wr_word = 0, sim_mode = 0, load = 0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [NCH*CW-1:0] dac_code;

  int lo_m [NCH];
  int pend_m [NCH];
  int dac_m [NCH];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dac_pair_latch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data), .sim_mode(sim_mode),
    .load(load), .dac_code(dac_code)
  );

  task automatic compare(string tag);
    for (int c = 0; c < NCH; c++) begin
      int got;
      got = int'(dac_code[c*CW +: CW]);
      n_chk++;
      if (got != dac_m[c]) begin
        n_fail++;
        $display("FAIL %s ch%0d: got 0x%03h expected 0x%03h", tag, c, got, dac_m[c]);
      end
    end
  endtask

  task automatic model_edge(bit en, bit wd, int a, int d, bit sm, bit ld);
    int ch, code;
    int old_pend [NCH];
    bit do_lo, do_hi;
    for (int c = 0; c < NCH; c++) old_pend[c] = pend_m[c];
    ch = a >> 1;
    if (en && ch < NCH) begin
      do_lo = wd || (a % 2 == 0);
      do_hi = wd || (a % 2 == 1);
      if (wd) code = (((d >> 8) & 8'hFF) << 4) | (d & 4'hF);
      else    code = ((d & 8'hFF) << 4) | lo_m[ch];
      if (do_lo) lo_m[ch] = d & 4'hF;
      if (do_hi) begin
        pend_m[ch] = code;
        if (!sm) dac_m[ch] = code;
      end
    end
    if (sm && ld)
      for (int c = 0; c < NCH; c++) dac_m[c] = old_pend[c];
  endtask

  task automatic cyc(bit en, bit wd, int a, int d, bit sm, bit ld, string tag);
    wr_en = en; wr_word = wd; wr_addr = 3'(a); wr_data = 16'(d);
    sim_mode = sm; load = ld;
    @(posedge clk);
    model_edge(en, wd, a, d, sm, ld);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin lo_m[c] = 0; pend_m[c] = 2048; dac_m[c] = 2048; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    cyc(1, 0, 0, 16'hFFA5, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 0, 1, 16'hEE3C, 0, 0, "R3");
    cyc(1, 0, 1, 16'h0012, 0, 0, "R5");
    cyc(1, 0, 1, 16'h00FF, 0, 1, "R6");
    cyc(1, 1, 2, 16'hABF7, 0, 0, "R4");
    cyc(1, 1, 3, 16'h1234, 0, 0, "R4");
    cyc(1, 0, 3, 16'h0099, 0, 0, "R5");
    cyc(1, 0, 4, 16'h000C, 0, 0, "R9");
    cyc(1, 0, 5, 16'h0077, 0, 0, "R9");
    cyc(1, 0, 6, 16'h000F, 0, 0, "R8");
    cyc(1, 0, 7, 16'h0055, 0, 0, "R8");
    cyc(1, 1, 7, 16'hFFFF, 0, 0, "R8");
    cyc(1, 0, 5, 16'h0011, 0, 0, "R8");

    cyc(1, 0, 1, 16'h0042, 1, 0, "R6");
    cyc(1, 1, 4, 16'h5A03, 1, 0, "R6");
    cyc(0, 0, 0, 0, 1, 0, "R6");
    cyc(0, 0, 0, 0, 1, 1, "R6");
    cyc(1, 0, 3, 16'h00C3, 1, 1, "R7");
    cyc(0, 0, 0, 0, 1, 0, "R7");
    cyc(0, 0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 0, 0, 0, "R6");

    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 7),
          $urandom_range(0, 65535), $urandom_range(0, 2) == 0,
          $urandom_range(0, 3) == 0, "R9");

    rst_n = 0;
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin lo_m[c] = 0; pend_m[c] = 2048; dac_m[c] = 2048; end
    @(negedge clk);
    rst_n = 1;
    compare("R1");
    cyc(1, 0, 1, 16'h0080, 0, 0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule